// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Unit

This block counts an event reported by the retirement stage of a pipeline, such as retired instructions or loads that hit or missed in a cache. When the counter wraps it raises a sampling request. Two delivery modes exist, chosen by a single mode input.

In skid mode the event takes a slow path. It crosses a fixed delay line before it reaches the counter. An overflow then crosses a second delay line, which stands for the interrupt controller, before it comes back as an interrupt request. Retirement keeps going while the request is in flight, so the sampled point lags the event that caused it. The block records how many instructions retired in that gap (the skid) and the tag of the youngest one. When the request arrives, the pipeline is expected to flush everything it holds.

In exact mode the event is carried with the instruction as part of its fault status. The counter acts on it at retirement. An overflow raises a trap request on the next cycle, naming that instruction, and the pipeline flushes only the instructions younger than it. Events that only happen after commit, such as store misses, cannot be attributed this way and are ignored in this mode.

The counter can be preloaded. On overflow it reloads the preload value, and a sticky overflow flag records that a wrap happened.

Top module: `perf_ovf_irq`

## Requirements
- R1: After reset, irq_req, trap_req and ovf_sticky are 0, and skid_cnt, smp_tag and cnt_val are all zero.
- R2: A cycle with cfg_load=1 sets cnt_val to cfg_preload on the next cycle. It takes priority over any event counted in that cycle, and that event is dropped.
- R3: A counted event with cnt_val equal to all ones wraps the counter to the current cfg_preload. From preload P, overflow happens on counted event number 2^CNT_W - P.
- R4: In skid mode (mode_exact=0) every retirement with ret_evt=1 counts, whatever ret_post is. The overflowing one produces a one-cycle irq_req exactly EVT_DLY+CTL_DLY cycles after its retire cycle.
- R5: During the irq_req cycle, skid_cnt equals the number of cycles with ret_vld=1 strictly between the overflowing retirement and the irq_req cycle.
- R6: During the irq_req cycle, smp_tag equals the ret_tag of the youngest instruction that retired before the irq_req cycle. This may be the overflowing instruction itself.
- R7: In exact mode (mode_exact=1) the overflowing retirement produces a one-cycle trap_req on the next cycle, with smp_tag equal to that retirement's ret_tag.
- R8: In exact mode a retirement with ret_post=1 is not counted: cnt_val does not change and no trap_req follows.
- R9: ovf_sticky goes to 1 on any overflow and stays 1 until a cycle with ovf_clr=1 clears it. If both happen in the same cycle, the overflow wins.
- R10: In exact mode no irq_req is produced for events retired in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_exact | input | 1 | 1 = exact (trap at retirement), 0 = skid (delayed interrupt) |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_tag | input | TAG_W | Identity of the retiring instruction |
| ret_evt | input | 1 | Retiring instruction carries the monitored event |
| ret_post | input | 1 | The event belongs to the after-commit class |
| cfg_load | input | 1 | Load cfg_preload into the counter |
| cfg_preload | input | CNT_W | Preload and reload value |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| irq_req | output | 1 | Skid-mode interrupt request; flush everything in flight |
| trap_req | output | 1 | Exact-mode trap request; flush instructions younger than smp_tag |
| smp_tag | output | TAG_W | Tag of the sampled instruction |
| skid_cnt | output | $clog2(EVT_DLY+CTL_DLY) | Retirements between overflow and irq_req |
| ovf_sticky | output | 1 | Sticky overflow flag |
| cnt_val | output | CNT_W | Current counter value |

## Verification
The bench builds the block with a 4-bit counter and the default delays of 3 and 4 cycles. This makes every one of the 16 preload values reachable with at most 16 events, so the wrap point is swept exhaustively in both modes, with random retire, event and after-commit patterns. A seven-cycle interrupt path leaves room for skid counts anywhere from zero up to six. Expected interrupt and trap cycles, skid counts and tags come from an event-order model that knows nothing about the delay lines.

// File: rtl/perf_ovf_pkg.sv
package perf_ovf_pkg;

  typedef enum logic {
    MODE_SKID  = 1'b0,
    MODE_EXACT = 1'b1
  } perf_mode_e;

  // Cycles from a skid-mode retirement to its interrupt request.
  function automatic int unsigned fire_latency(int unsigned evt_dly, int unsigned ctl_dly);
    return evt_dly + ctl_dly;
  endfunction

endpackage

// File: rtl/perf_ovf_dly.sv
// Single-bit delay line of DEPTH register stages.
module perf_ovf_dly #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] stg;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/perf_ovf_cnt.sv
// Preloadable up-counter that reloads its preload value on wrap.
module perf_ovf_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  // {wrapped, next value} for one counted event.
  function automatic logic [CNT_W:0] step_count(logic [CNT_W-1:0] cur, logic [CNT_W-1:0] pre);
    if (cur == {CNT_W{1'b1}}) return {1'b1, pre};
    return {1'b0, cur + CNT_W'(1)};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             wrap_raw;

  always_comb {wrap_raw, nxt} = step_count(cnt_q, preload);

  assign wrap = inc & ~load & wrap_raw;
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (load) cnt_q <= preload;
    else if (inc)  cnt_q <= nxt;
  end

endmodule

// File: rtl/perf_ovf_skid.sv
// Counts retirements between a skid-mode overflow and its delivery.
module perf_ovf_skid #(
  parameter int unsigned HW = 2,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [HW-1:0] hist,
  input  logic          ret_vld,
  input  logic          window,
  output logic [SW-1:0] skid_cnt
);

  // Retirements already seen when the overflow is detected.
  function automatic logic [SW-1:0] seed_of(logic [HW-1:0] h, logic now);
    logic [SW-1:0] s;
    s = SW'(now);
    for (int i = 0; i < int'(HW); i++) s = s + SW'(h[i]);
    return s;
  endfunction

  logic [SW-1:0] skid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 skid_q <= '0;
    else if (launch)            skid_q <= seed_of(hist, ret_vld);
    else if (window && ret_vld) skid_q <= skid_q + SW'(1);
  end

  assign skid_cnt = skid_q;

endmodule

// File: rtl/perf_ovf_irq.sv
module perf_ovf_irq
  import perf_ovf_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned EVT_DLY = 3,   // retirement -> counter, >= 2
  parameter int unsigned CTL_DLY = 4,   // overflow -> interrupt request, >= 2
  parameter int unsigned TAG_W   = 8,
  localparam int unsigned LAT    = fire_latency(EVT_DLY, CTL_DLY),
  localparam int unsigned SKID_W = $clog2(LAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_exact,
  input  logic              ret_vld,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              ret_evt,
  input  logic              ret_post,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_preload,
  input  logic              ovf_clr,
  output logic              irq_req,
  output logic              trap_req,
  output logic [TAG_W-1:0]  smp_tag,
  output logic [SKID_W-1:0] skid_cnt,
  output logic              ovf_sticky,
  output logic [CNT_W-1:0]  cnt_val
);

  localparam int unsigned HW = EVT_DLY - 1;

  perf_mode_e mode;
  assign mode = perf_mode_e'(mode_exact);

  // Named internal events
  logic cnt_exact;    // exact-mode event counted at retirement
  logic evt_skid_in;  // skid-mode event entering the slow path
  logic evt_at_cnt;   // skid-mode event reaching the counter
  logic wrap;         // counter wrapped this cycle
  logic ovf_exact;    // exact-mode overflow
  logic launch;       // skid-mode overflow entering the controller path
  logic window;       // skid request in flight, not yet delivered
  logic tag_cap;      // last cycle before delivery

  assign cnt_exact   = ret_vld & ret_evt & ~ret_post & (mode == MODE_EXACT);
  assign evt_skid_in = ret_vld & ret_evt & (mode == MODE_SKID);

  perf_ovf_dly #(.DEPTH(EVT_DLY)) u_evt_line (
    .clk (clk),
    .rst_n (rst_n),
    .d (evt_skid_in),
    .q (evt_at_cnt)
  );

  perf_ovf_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst_n (rst_n),
    .load (cfg_load),
    .preload (cfg_preload),
    .inc (cnt_exact | evt_at_cnt),
    .cnt (cnt_val),
    .wrap (wrap)
  );

  assign ovf_exact = wrap & cnt_exact;
  assign launch    = wrap & ~cnt_exact;

  // Interrupt-controller path
  logic [CTL_DLY-1:0] ctl_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= {ctl_q[CTL_DLY-2:0], launch};
  end
  assign irq_req = ctl_q[CTL_DLY-1];
  assign window  = |ctl_q[CTL_DLY-2:0];
  assign tag_cap = ctl_q[CTL_DLY-2];

  // Retirement history covering the slow event path
  logic [HW-1:0] hist_q;
  generate
    if (HW == 1) begin : g_hist_one
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= ret_vld;
      end
    end else begin : g_hist_many
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HW-2:0], ret_vld};
      end
    end
  endgenerate

  perf_ovf_skid #(.HW(HW), .SW(SKID_W)) u_skid (
    .clk (clk),
    .rst_n (rst_n),
    .launch (launch),
    .hist (hist_q),
    .ret_vld (ret_vld),
    .window (window),
    .skid_cnt (skid_cnt)
  );

  logic [TAG_W-1:0] last_tag;
  logic             trap_q;
  logic             sticky_q;
  logic [TAG_W-1:0] smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_tag <= '0;
      trap_q   <= 1'b0;
      sticky_q <= 1'b0;
      smp_q    <= '0;
    end else begin
      if (ret_vld) last_tag <= ret_tag;
      trap_q <= ovf_exact;
      if (ovf_exact || launch) sticky_q <= 1'b1;
      else if (ovf_clr)        sticky_q <= 1'b0;
      if (ovf_exact)    smp_q <= ret_tag;
      else if (tag_cap) smp_q <= ret_vld ? ret_tag : last_tag;
    end
  end

  assign trap_req   = trap_q;
  assign ovf_sticky = sticky_q;
  assign smp_tag    = smp_q;

endmodule

// File: rtl/perf_ovf_irq_chk.sv
module perf_ovf_irq_chk #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CTL_DLY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_exact,
  input logic             ret_vld,
  input logic             ret_evt,
  input logic             ret_post,
  input logic             cfg_load,
  input logic [CNT_W-1:0] cfg_preload,
  input logic             ovf_clr,
  input logic             irq_req,
  input logic             trap_req,
  input logic             ovf_sticky,
  input logic [CNT_W-1:0] cnt_val,
  input logic             launch
);

  // Cycles since the latest skid-mode launch, saturating.
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)             gap <= 8'hFF;
    else if (launch)        gap <= 8'd1;
    else if (gap != 8'hFF)  gap <= gap + 8'd1;
  end

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cnt_val == $past(cfg_preload));

  p_irq_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gap == 8'(CTL_DLY));

  p_trap_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(ret_vld && ret_evt && !ret_post && mode_exact));

  p_post_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_exact && ret_vld && ret_post) |=> !trap_req);

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  p_trap_sets_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ovf_sticky);

endmodule

bind perf_ovf_irq perf_ovf_irq_chk #(.CNT_W(CNT_W), .CTL_DLY(CTL_DLY)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .mode_exact (mode_exact),
  .ret_vld (ret_vld),
  .ret_evt (ret_evt),
  .ret_post (ret_post),
  .cfg_load (cfg_load),
  .cfg_preload (cfg_preload),
  .ovf_clr (ovf_clr),
  .irq_req (irq_req),
  .trap_req (trap_req),
  .ovf_sticky (ovf_sticky),
  .cnt_val (cnt_val),
  .launch (launch)
);

// File: tb/perf_ovf_irq_bench.sv
`timescale 1ns/1ps
module perf_ovf_irq_bench;
  localparam int CW = 4, ED = 3, CD = 4, TW = 8;
  localparam int LAT = ED + CD;
  localparam int SW = $clog2(LAT);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode_exact, ret_vld, ret_evt, ret_post, cfg_load, ovf_clr;
  logic [TW-1:0] ret_tag;
  logic [CW-1:0] cfg_preload;
  logic irq_req, trap_req, ovf_sticky;
  logic [TW-1:0] smp_tag;
  logic [SW-1:0] skid_cnt;
  logic [CW-1:0] cnt_val;

  perf_ovf_irq #(.CNT_W(CW), .EVT_DLY(ED), .CTL_DLY(CD), .TAG_W(TW)) u_perf_ovf_irq (
    .clk(clk), .rst_n(rst_n), .mode_exact(mode_exact), .ret_vld(ret_vld),
    .ret_tag(ret_tag), .ret_evt(ret_evt), .ret_post(ret_post),
    .cfg_load(cfg_load), .cfg_preload(cfg_preload), .ovf_clr(ovf_clr),
    .irq_req(irq_req), .trap_req(trap_req), .smp_tag(smp_tag),
    .skid_cnt(skid_cnt), .ovf_sticky(ovf_sticky), .cnt_val(cnt_val));

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int exp_irq_cyc = -1, exp_trap_cyc = -1, ovf_cyc = -1;
  int skid_acc = 0, ref_cnt = 0, pre_ref = 0;
  int want_cnt = -1, want_sticky = -1;
  logic [TW-1:0] pend_tag, exact_tag;
  logic [15:0] lfsr = 16'hACE1;
  bit ovf_seen = 0, done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One cycle: check outputs visible now, then apply this cycle's inputs.
  task automatic tick(input logic v, input logic e, input logic p,
                      input logic ld, input logic clr);
    logic [TW-1:0] t;
    @(negedge clk);
    t = cyc[TW-1:0];
    check("R4,R10 irq_req timing", irq_req, cyc == exp_irq_cyc);
    check("R7 trap_req timing", trap_req, cyc == exp_trap_cyc);
    if (cyc == exp_irq_cyc) begin
      check("R5 skid count", skid_cnt, skid_acc);
      check("R6 skid sample tag", smp_tag, pend_tag);
    end
    if (cyc == exp_trap_cyc) check("R7 exact sample tag", smp_tag, exact_tag);
    if (want_cnt >= 0)    check("R2,R3,R8 counter value", cnt_val, want_cnt);
    if (want_sticky >= 0) check("R9 sticky flag", ovf_sticky, want_sticky);
    want_cnt = -1; want_sticky = -1;
    ret_vld = v; ret_evt = e; ret_post = p; ret_tag = t;
    cfg_load = ld; ovf_clr = clr; cfg_preload = pre_ref[CW-1:0];
    // reference model in event order
    if (ovf_cyc >= 0 && cyc > ovf_cyc && cyc < exp_irq_cyc && v) begin
      skid_acc++; pend_tag = t;
    end
    if (ld) ref_cnt = pre_ref;
    else if (v && e && !(mode_exact && p)) begin
      if (ref_cnt == (1 << CW) - 1) begin
        ref_cnt = pre_ref; ovf_seen = 1;
        if (mode_exact) begin exp_trap_cyc = cyc + 1; exact_tag = t; end
        else begin exp_irq_cyc = cyc + LAT; ovf_cyc = cyc; skid_acc = 0; pend_tag = t; end
      end else ref_cnt++;
    end
    cyc++;
  endtask

  task automatic run_case(input bit m, input int pv);
    mode_exact = m; pre_ref = pv; ovf_seen = 0;
    tick(0, 0, 0, 1, 0);
    want_cnt = pv;                       // R2
    while (!ovf_seen) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[2] & lfsr[7], 0, 0);
    end
    for (int i = 0; i < LAT + 3; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0], 0, 0, 0, 0);
    end
    want_cnt = pv; want_sticky = 1;      // R3 wrap to preload, R9 set
    tick(0, 0, 0, 0, 1);
    want_sticky = 0;                     // R9 cleared
    tick(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_exact = 0; ret_vld = 0; ret_evt = 0; ret_post = 0;
    ret_tag = '0; cfg_load = 0; cfg_preload = '0; ovf_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset irq_req", irq_req, 0);
    check("R1 reset trap_req", trap_req, 0);
    check("R1 reset sticky", ovf_sticky, 0);
    check("R1 reset skid_cnt", skid_cnt, 0);
    check("R1 reset smp_tag", smp_tag, 0);
    check("R1 reset cnt_val", cnt_val, 0);
    cyc = 1;

    // exhaustive preload sweep, both modes
    for (int pv = 0; pv < (1 << CW); pv++) run_case(1'b1, pv);
    for (int pv = 0; pv < (1 << CW); pv++) run_case(1'b0, pv);

    // R8: after-commit event at the wrap point is ignored in exact mode
    mode_exact = 1; pre_ref = 15;
    tick(0, 0, 0, 1, 0);
    tick(1, 1, 1, 0, 0);
    want_cnt = 15;
    tick(0, 0, 0, 0, 0);
    // R2: load wins over a simultaneous counted event
    pre_ref = 9;
    tick(1, 1, 0, 1, 0);
    want_cnt = 9;
    tick(0, 0, 0, 0, 0);
    // R9: overflow beats a same-cycle clear
    pre_ref = 15;
    tick(0, 0, 0, 1, 0);
    tick(1, 1, 0, 0, 1);
    want_sticky = 1;
    tick(0, 0, 0, 0, 0);
    repeat (3) tick(0, 0, 0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule